// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational 20-bit binary adder. It takes two operands and a carry-in, and returns a 20-bit sum and a carry-out. The operand is cut into five stages whose widths grow by one bit from one stage to the next: 2, 3, 4, 5 and 6 bits. Because the widths grow, the carry that selects each stage's result arrives at about the time that stage's precomputed results are ready.

Each stage first forms a per-bit propagate (`a xor b`) and a per-bit generate (`a and b`). Every stage except the lowest then runs two ripple chains side by side. One chain assumes an incoming carry of 0 and the other assumes 1. The real carry that arrives from the stage below drives a multiplexer, which picks one of the two carry vectors. The sum bits are formed from the chosen vector, and the chosen stage carry-out selects for the next stage. The lowest stage ripples from the real carry-in directly. The carry-out of the top stage drives the adder's carry-out.

The stage layout is derived from two parameters, the width of the first stage and the number of stages. Changing the sizing pattern needs no change to the logic.

Top module: `sqsel_adder`

## Requirements
- R1: For any operands and carry-in, `{cout_o, sum_o}` equals the 21-bit value `a_i + b_i + cin_i`, with no clock and no latency.
- R2: The stages cover bits [1:0], [4:2], [8:5], [13:9] and [19:14]. A carry generated at the top bit of a stage (bit 1, 4, 8 or 13) lands in the lowest bit of the next stage (bit 2, 5, 9 or 14).
- R3: When every bit of a stage propagates (`a xor b` all ones) and a carry enters that stage, the stage's sum bits are all zero and the carry passes on to the next stage, or to `cout_o` for the top stage.
- R4: `cin_i` is added at bit 0. For the same operands, setting `cin_i` to 1 raises the result by exactly one, including when that one ripples out of the lowest stage.
- R5: `cout_o` is the carry out of bit 19. 0xFFFFF + 0 + 1 gives sum 0 with `cout_o` = 1. 0x80000 + 0x7FFFF + 0 gives 0xFFFFF with `cout_o` = 0.
- R6: All-zero operands with `cin_i` = 0 give a zero sum and `cout_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 20 | First operand |
| b_i | input | 20 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 20 | Sum bits |
| cout_o | output | 1 | Carry out of bit 19 |

## Verification
Every result is due in the same cycle as its stimulus, since no register lies between the inputs and the outputs. The bench drives a new operand set just after a rising edge and queues the expected sum and carry-out. It compares them at the following falling edge, half a period later, once the combinational paths have settled and before the next stimulus is applied. Directed vectors place carries on each stage boundary and across whole propagating stages, with both carry-in values. Random operands then cover the general case.

// File: rtl/sqsel_pkg.sv
package sqsel_pkg;

  // Lowest bit index of stage k when stage widths grow by one from first_w.
  function automatic int stage_lo(input int first_w, input int k);
    return k * first_w + (k * (k - 1)) / 2;
  endfunction

  // Width of stage k.
  function automatic int stage_w(input int first_w, input int k);
    return first_w + k;
  endfunction

  // Total operand width covered by n stages.
  function automatic int total_w(input int first_w, input int n);
    return stage_lo(first_w, n);
  endfunction

endpackage

// File: rtl/sqsel_setup.sv
module sqsel_setup #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prop_o,
  output logic [W-1:0] gen_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign prop_o[i] = a_i[i] ^ b_i[i];
    assign gen_o[i]  = a_i[i] & b_i[i];
  end

endmodule

// File: rtl/sqsel_chain.sv
module sqsel_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] prop_i,
  input  logic [W-1:0] gen_i,
  input  logic         cin_i,
  output logic [W:0]   carry_o
);

  // Ripple chain: bit i+1 carry is generate or (propagate and bit i carry).
  function automatic logic [W:0] run_chain(input logic [W-1:0] p,
                                           input logic [W-1:0] g,
                                           input logic c0);
    logic [W:0] c;
    c[0] = c0;
    for (int i = 0; i < W; i++) begin
      c[i+1] = g[i] | (p[i] & c[i]);
    end
    return c;
  endfunction

  always_comb carry_o = run_chain(prop_i, gen_i, cin_i);

  // R3: with no propagating bit, the chain end depends only on the top generate.
  always_comb begin
    if (prop_i == '0) begin
      assert_chain_kill_R3: assert (carry_o[W] == gen_i[W-1])
        else $error("chain end ignores kill/generate at top bit");
    end
  end

endmodule

// File: rtl/sqsel_stage.sv
module sqsel_stage #(
  parameter int W      = 4,
  parameter bit DIRECT = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] prop_w;
  logic [W-1:0] gen_w;
  logic [W:0]   carry_sel_w;

  sqsel_setup #(.W(W)) setup_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .prop_o (prop_w),
    .gen_o  (gen_w)
  );

  if (DIRECT) begin : g_direct
    sqsel_chain #(.W(W)) chain_i (
      .prop_i  (prop_w),
      .gen_i   (gen_w),
      .cin_i   (cin_i),
      .carry_o (carry_sel_w)
    );
  end else begin : g_dual
    logic [W:0] carry_zero_w;
    logic [W:0] carry_one_w;

    sqsel_chain #(.W(W)) chain_zero_i (
      .prop_i  (prop_w),
      .gen_i   (gen_w),
      .cin_i   (1'b0),
      .carry_o (carry_zero_w)
    );

    sqsel_chain #(.W(W)) chain_one_i (
      .prop_i  (prop_w),
      .gen_i   (gen_w),
      .cin_i   (1'b1),
      .carry_o (carry_one_w)
    );

    assign carry_sel_w = cin_i ? carry_one_w : carry_zero_w;

    // R4: a chain assuming carry 1 never holds a 0 where the carry-0 chain holds a 1.
    always_comb begin
      assert_chain_order_R4: assert ((carry_zero_w & ~carry_one_w) == '0)
        else $error("carry-0 chain exceeds carry-1 chain");
    end
  end

  assign sum_o  = prop_w ^ carry_sel_w[W-1:0];
  assign cout_o = carry_sel_w[W];

  // R1: stage slice adds correctly on its own.
  always_comb begin
    assert_stage_sum_R1: assert ({cout_o, sum_o} ==
                                 ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("stage slice sum mismatch");
  end

  // R3: an all-propagate stage forwards its incoming carry.
  always_comb begin
    if (&(a_i ^ b_i)) begin
      assert_stage_fwd_R3: assert (cout_o == cin_i && sum_o == {W{~cin_i}})
        else $error("all-propagate stage did not forward carry");
    end
  end

endmodule

// File: rtl/sqsel_adder.sv
module sqsel_adder
  import sqsel_pkg::*;
#(
  parameter int FIRST_W    = 2,
  parameter int NUM_STAGES = 5
) (
  input  logic [total_w(FIRST_W, NUM_STAGES)-1:0] a_i,
  input  logic [total_w(FIRST_W, NUM_STAGES)-1:0] b_i,
  input  logic                                     cin_i,
  output logic [total_w(FIRST_W, NUM_STAGES)-1:0] sum_o,
  output logic                                     cout_o
);

  localparam int WIDTH = total_w(FIRST_W, NUM_STAGES);

  // Carry entering each stage; entry NUM_STAGES is the adder carry-out.
  logic stage_carry_w [NUM_STAGES+1];

  assign stage_carry_w[0] = cin_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    localparam int SLO = stage_lo(FIRST_W, k);
    localparam int SW  = stage_w(FIRST_W, k);

    sqsel_stage #(
      .W      (SW),
      .DIRECT (k == 0)
    ) stage_i (
      .a_i    (a_i[SLO +: SW]),
      .b_i    (b_i[SLO +: SW]),
      .cin_i  (stage_carry_w[k]),
      .sum_o  (sum_o[SLO +: SW]),
      .cout_o (stage_carry_w[k+1])
    );
  end

  assign cout_o = stage_carry_w[NUM_STAGES];

  // R1: full-width result equals the arithmetic sum.
  always_comb begin
    assert_full_sum_R1: assert ({cout_o, sum_o} ==
                                ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("adder result mismatch");
  end

  // R5: a generate at the top bit always leaves as carry-out.
  always_comb begin
    if (a_i[WIDTH-1] & b_i[WIDTH-1]) begin
      assert_cout_gen_R5: assert (cout_o)
        else $error("top-bit generate lost");
    end
  end

  // R3: an all-propagate word passes carry-in straight to carry-out.
  always_comb begin
    if (&(a_i ^ b_i)) begin
      assert_word_fwd_R3: assert (cout_o == cin_i)
        else $error("all-propagate word did not forward carry-in");
    end
  end

endmodule

// File: tb/sqsel_adder_tb.sv
module sqsel_adder_tb_top;

  logic        clk = 1'b0;
  logic [19:0] a_s = '0;
  logic [19:0] b_s = '0;
  logic        cin_s = 1'b0;
  logic [19:0] sum_s;
  logic        cout_s;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [19:0] exp_sum;
    logic        exp_cout;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  sqsel_adder dut_i (
    .a_i    (a_s),
    .b_i    (b_s),
    .cin_i  (cin_s),
    .sum_o  (sum_s),
    .cout_o (cout_s)
  );

  // Driver: apply operands after a rising edge and queue the expectation.
  task automatic drive(input logic [19:0] a, input logic [19:0] b, input logic c,
                       input logic [19:0] es, input logic ec, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    a_s = a;
    b_s = b;
    cin_s = c;
    e.exp_sum = es;
    e.exp_cout = ec;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Expected value from plain integer arithmetic.
  task automatic drive_arith(input logic [19:0] a, input logic [19:0] b, input logic c,
                             input string tag);
    longint unsigned t;
    t = longint'(a) + longint'(b) + longint'(c);
    drive(a, b, c, t[19:0], t[20], tag);
  endtask

  // Monitor: compare at the falling edge, half a period after the stimulus.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (sum_s !== e.exp_sum || cout_s !== e.exp_cout) begin
          failures++;
          $display("FAIL %s: got sum=%05h cout=%0b expected sum=%05h cout=%0b",
                   e.tag, sum_s, cout_s, e.exp_sum, e.exp_cout);
        end
      end
    end
  end

  initial begin
    int lo_tab [5] = '{0, 2, 5, 9, 14};
    int w_tab  [5] = '{2, 3, 4, 5, 6};
    int hi_tab [4] = '{1, 4, 8, 13};

    // R6: zero in, zero out.
    drive(20'h0, 20'h0, 1'b0, 20'h0, 1'b0, "R6 zero operands");

    // R4: carry-in handling in the lowest stage.
    drive(20'h0, 20'h0, 1'b1, 20'h1, 1'b0, "R4 cin only");
    drive(20'h3, 20'h0, 1'b0, 20'h3, 1'b0, "R4 3+0+0");
    drive(20'h3, 20'h0, 1'b1, 20'h4, 1'b0, "R4 3+0+1 out of stage 0");
    drive(20'h12345, 20'h0ABCD, 1'b0, 20'h1CF12, 1'b0, "R4 mid cin0");
    drive(20'h12345, 20'h0ABCD, 1'b1, 20'h1CF13, 1'b0, "R4 mid cin1");

    // R2: generate at each stage top bit lands in the next stage.
    foreach (hi_tab[i]) begin
      drive(20'h1 << hi_tab[i], 20'h1 << hi_tab[i], 1'b0,
            20'h1 << (hi_tab[i] + 1), 1'b0, "R2 boundary generate");
      drive(20'h1 << hi_tab[i], 20'h1 << hi_tab[i], 1'b1,
            (20'h1 << (hi_tab[i] + 1)) | 20'h1, 1'b0, "R2 boundary generate cin1");
    end

    // R3: carry into an all-propagate stage passes straight through it.
    for (int k = 1; k < 5; k++) begin
      logic [20:0] mask;
      logic [20:0] res;
      mask = ((21'h1 << w_tab[k]) - 21'h1) << lo_tab[k];
      res  = 21'h1 << (lo_tab[k] + w_tab[k]);
      drive(mask[19:0] | (20'h1 << (lo_tab[k] - 1)), 20'h1 << (lo_tab[k] - 1), 1'b0,
            res[19:0], res[20], "R3 stage pass-through");
    end
    drive(20'h00003, 20'h0, 1'b1, 20'h4, 1'b0, "R3 stage 0 pass-through");

    // R5: carry out of bit 19.
    drive(20'hFFFFF, 20'h0, 1'b1, 20'h0, 1'b1, "R5 full ripple");
    drive(20'h80000, 20'h7FFFF, 1'b0, 20'hFFFFF, 1'b0, "R5 no carry out");
    drive(20'h80000, 20'h7FFFF, 1'b1, 20'h0, 1'b1, "R5 carry out by cin");
    drive(20'h80000, 20'h80000, 1'b0, 20'h0, 1'b1, "R5 top generate");

    // R1: random operands with both carry-in values.
    for (int n = 0; n < 200; n++) begin
      drive_arith(20'($urandom), 20'($urandom), n[0], "R1 random");
    end

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Watchdog.
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule